// File: doc/BRIEF.md
# Pulse-Position ASK Bit Encoder

This block turns a serial bit stream into the on/off gate for a carrier keyed with modulation index 1. The gate stays off except during short pulses. Each bit period starts with a pulse that also closes the previous bit. A second pulse falls inside the period, and its position carries the bit: early for one value, late for the other. Before the pulse is placed, the bit is transition-encoded. A data 1 flips the transmitted level and a data 0 keeps it, so a receiver that recovers an inverted level still decodes the data correctly.

The bit period and the pulse width are runtime inputs counted in system-clock cycles. Bits enter over a valid/ready handshake, and a bit is taken only at a bit boundary. A stream of bits with valid held high is sent back to back with no gap. When the stream ends, one trailing start pulse is sent so the receiver can close the last bit, and the block then goes idle with the gate off.

Top module: `ppm_ask_encoder`

## Requirements
- R1: When a bit is accepted (valid_i and ready_o high at a clock edge), gate_o goes high in the next cycle. That cycle is count 0 of the bit period, and the start pulse covers counts 0 to ton-1.
- R2: Let P be the latched bit period. When the transmitted level is 1, the mid-bit pulse starts at count floor(3P/5). When it is 0, the pulse starts at count floor(2P/5).
- R3: Each pulse lasts exactly ton cycles. Outside the pulses gate_o is low, including in the last cycle of every bit period.
- R4: The transmitted level equals the previous transmitted level XOR the data bit. It resets to 0 and is kept from one burst to the next.
- R5: ready_o is high only when the block is idle or in the last cycle (count P-1) of a bit period. A bit accepted in that last cycle starts at count 0 in the next cycle, with no gap.
- R6: When no bit is accepted at the end of a period, gate_o stays high for ton more cycles as a trailing start pulse. busy_o then falls and gate_o stays low.
- R7: When no bit is offered, gate_o and busy_o stay low.
- R8: cfg_err_o is high when ton_i is 0 or ton_i >= floor(2*period_i/5). While cfg_err_o is high, ready_o is low and no bit is taken.
- R9: While en_i is low, ready_o is low and offered bits are ignored. The gate stays off and the transmitted level is unchanged.
- R10: Each bit produces exactly two rising edges on gate_o (four transitions). A burst of n bits produces 2n+1 rising edges in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Allows new bits to be accepted |
| period_i | input | CNT_W | Bit period in clock cycles |
| ton_i | input | CNT_W | Pulse width in clock cycles |
| data_i | input | 1 | Data bit |
| valid_i | input | 1 | data_i is offered |
| ready_o | output | 1 | A bit can be taken this cycle |
| gate_o | output | 1 | Carrier on/off gate |
| busy_o | output | 1 | A bit or the trailing pulse is in progress |
| cfg_err_o | output | 1 | period_i/ton_i combination is illegal |

## Verification
The bench builds the block with an 8-bit counter width, so periods of a few cycles up to 23 cycles can be tested in a short run. This covers the smallest legal period of 5 cycles, where the two mid-bit positions are only one cycle apart. It also covers the boundary at a period of 10 cycles, where a pulse width of 3 is accepted and a width of 4 is flagged. Bursts mix runs of ones and zeros, so the transmitted level both flips and holds, and the level is carried over from one burst to the next.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_TAIL = 2'd2
  } ppm_state_e;

  // mid-pulse offsets as fractions of the period
  localparam int unsigned MID_HI  = 3;
  localparam int unsigned MID_LO  = 2;
  localparam int unsigned MID_DEN = 5;
endpackage

// File: rtl/ppm_cfg_check.sv
module ppm_cfg_check #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] ton_i,
  output logic             err_o
);
  import ppm_pkg::*;
  localparam int unsigned XW = CNT_W + 3;

  logic [XW-1:0] lim_x;

  assign lim_x = (XW'(period_i) * XW'(MID_LO)) / XW'(MID_DEN);
  assign err_o = (ton_i == '0) || (XW'(ton_i) >= lim_x);
endmodule

// File: rtl/ppm_diff_coder.sv
module ppm_diff_coder (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bit_i,
  output logic level_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     level_q <= 1'b0;
    else if (load_i) level_q <= level_q ^ bit_i;
  end

  assign level_o = level_q;

  a_r4_toggle_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && bit_i) |=> (level_o != $past(level_o)));
  a_r4_hold_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !bit_i) |=> $stable(level_o));
  a_r4_hold_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(level_o));
endmodule

// File: rtl/ppm_symbol_timer.sv
module ppm_symbol_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cfg_err_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] ton_i,
  input  logic             valid_i,
  input  logic             level_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             gate_o,
  output logic             busy_o
);
  import ppm_pkg::*;
  localparam int unsigned XW = CNT_W + 3;

  ppm_state_e       st_q;
  logic [CNT_W-1:0] cnt_q, p_q, t_q;
  logic             last_cyc, tail_end, boundary;
  logic [XW-1:0]    c_x, t_x, mid_x;

  assign last_cyc = (st_q == ST_BIT) && (cnt_q == p_q - 1'b1);
  assign tail_end = (st_q == ST_TAIL) && (cnt_q == t_q - 1'b1);
  assign boundary = (st_q == ST_IDLE) || last_cyc;
  assign ready_o  = en_i && !cfg_err_i && boundary;
  assign accept_o = ready_o && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      p_q   <= '0;
      t_q   <= '0;
    end else begin
      if (accept_o) begin
        p_q <= period_i;
        t_q <= ton_i;
      end
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (accept_o) st_q <= ST_BIT;
        end
        ST_BIT: begin
          if (last_cyc) begin
            cnt_q <= '0;
            if (!accept_o) st_q <= ST_TAIL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tail_end) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign c_x   = XW'(cnt_q);
  assign t_x   = XW'(t_q);
  assign mid_x = (XW'(p_q) * (level_i ? XW'(MID_HI) : XW'(MID_LO))) / XW'(MID_DEN);

  always_comb begin
    unique case (st_q)
      ST_BIT:  gate_o = (c_x < t_x) || ((c_x >= mid_x) && (c_x < mid_x + t_x));
      ST_TAIL: gate_o = 1'b1;
      default: gate_o = 1'b0;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);

  a_r1_start_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> gate_o);
  a_r3_boundary_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_cyc |-> !gate_o);
  a_r5_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIT) |-> (cnt_q < p_q));
  a_r6_tail_ends_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_end |=> !busy_o);
endmodule

// File: rtl/ppm_ask_encoder.sv
module ppm_ask_encoder #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] ton_i,
  input  logic             data_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             gate_o,
  output logic             busy_o,
  output logic             cfg_err_o
);
  logic cfg_err, accept, level;

  ppm_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .period_i (period_i),
    .ton_i    (ton_i),
    .err_o    (cfg_err)
  );

  ppm_diff_coder u_diff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .bit_i   (data_i),
    .level_o (level)
  );

  ppm_symbol_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .cfg_err_i (cfg_err),
    .period_i  (period_i),
    .ton_i     (ton_i),
    .valid_i   (valid_i),
    .level_i   (level),
    .ready_o   (ready_o),
    .accept_o  (accept),
    .gate_o    (gate_o),
    .busy_o    (busy_o)
  );

  assign cfg_err_o = cfg_err;

  a_r7_idle_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !gate_o);
endmodule

// File: tb/ppm_ask_encoder_tb.sv
module ppm_ask_encoder_tb;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [W-1:0] period_i = 8'd10;
  logic [W-1:0] ton_i = 8'd2;
  logic         data_i = 1'b0;
  logic         valid_i = 1'b0;
  logic         ready_o, gate_o, busy_o, cfg_err_o;

  int n_chk = 0;
  int n_err = 0;
  bit tx_m  = 1'b0;

  always #10 clk = ~clk;

  ppm_ask_encoder #(.CNT_W(W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .period_i  (period_i),
    .ton_i     (ton_i),
    .data_i    (data_i),
    .valid_i   (valid_i),
    .ready_o   (ready_o),
    .gate_o    (gate_o),
    .busy_o    (busy_o),
    .cfg_err_o (cfg_err_o)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic bit exp_gate(input int c, input int p, input int t, input bit lvl);
    int m;
    m = lvl ? (3 * p) / 5 : (2 * p) / 5;
    return (c < t) || (c >= m && c < m + t);
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0;
    en_i = 1'b1; valid_i = 1'b0; period_i = 8'd10; ton_i = 8'd2;
    repeat (3) @(negedge clk);
    chk("R7 reset gate", gate_o, 0);
    chk("R7 reset busy", busy_o, 0);
    rst_ni = 1'b1;
    tx_m = 1'b0;
    @(negedge clk);
    chk("R5 idle ready", ready_o, 1);
    chk("R8 legal cfg", cfg_err_o, 0);
  endtask

  // sends n bits back to back; checks gate every cycle
  task automatic t_frame(input int p, input int t, input logic [15:0] bits, input int n);
    int  rises;
    bit  prev;
    rises = 0;
    prev  = 1'b0;
    @(negedge clk);
    period_i = W'(p); ton_i = W'(t);
    data_i = bits[0]; valid_i = 1'b1;
    #1;
    chk("R5 ready before burst", ready_o, 1);
    for (int i = 0; i < n; i++) begin
      tx_m = tx_m ^ bits[i];
      @(posedge clk);
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        if (c == 0) begin
          valid_i = (i + 1 < n);
          data_i  = (i + 1 < n) ? bits[i+1] : 1'b0;
        end
        if (gate_o && !prev) rises++;
        prev = gate_o;
        chk((c < t) ? "R1 start pulse" : "R2 R3 mid pulse / off", gate_o, int'(exp_gate(c, p, t, tx_m)));
        chk("R6 busy in bit", busy_o, 1);
        if (c == 0) chk("R5 no ready mid-bit", ready_o, 0);
        if (c == p - 1) chk("R5 ready at boundary", ready_o, 1);
      end
    end
    for (int c = 0; c < t; c++) begin
      @(negedge clk);
      if (gate_o && !prev) rises++;
      prev = gate_o;
      chk("R6 trailing pulse", gate_o, 1);
    end
    @(negedge clk);
    chk("R6 gate off after tail", gate_o, 0);
    chk("R6 busy low after tail", busy_o, 0);
    chk("R10 rising edges", rises, 2 * n + 1);
  endtask

  task automatic t_no_data();
    valid_i = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (gate_o || busy_o) chk("R7 idle quiet", {gate_o, busy_o}, 0);
    end
    chk("R7 idle gate", gate_o, 0);
  endtask

  task automatic t_cfg_err();
    @(negedge clk);
    period_i = 8'd10; ton_i = 8'd4; valid_i = 1'b1; data_i = 1'b1;
    #1;
    chk("R8 ton at 40% flagged", cfg_err_o, 1);
    chk("R8 ready blocked", ready_o, 0);
    repeat (15) @(negedge clk);
    chk("R8 gate stays off", gate_o, 0);
    chk("R8 busy stays low", busy_o, 0);
    ton_i = 8'd0;
    #1;
    chk("R8 zero ton flagged", cfg_err_o, 1);
    valid_i = 1'b0; ton_i = 8'd3;
    #1;
    chk("R8 ton 3 of 10 legal", cfg_err_o, 0);
  endtask

  task automatic t_disabled();
    @(negedge clk);
    en_i = 1'b0; period_i = 8'd10; ton_i = 8'd2; valid_i = 1'b1; data_i = 1'b1;
    #1;
    chk("R9 ready low when disabled", ready_o, 0);
    repeat (15) @(negedge clk);
    chk("R9 gate off when disabled", gate_o, 0);
    chk("R9 busy low when disabled", busy_o, 0);
    valid_i = 1'b0; en_i = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(10, 2, 16'b0000_0000_0001_1101, 5);  // bits 1,0,1,1,1
    t_no_data();
    t_frame(23, 4, 16'b0000_0000_0000_0100, 4);  // 0,0,1,0: level carried over (R4)
    t_cfg_err();
    t_disabled();                                // level must stay unchanged
    t_frame(5, 1, 16'b0000_0000_0000_1010, 4);   // smallest legal period
    t_frame(10, 3, 16'b0000_0000_0000_0011, 3);  // ton at the legal limit
    t_reset();
    t_frame(12, 2, 16'b0000_0000_0000_0000, 2);  // R4 level from reset is 0
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule